// File: doc/BRIEF.md
# Battery charge cycle sequencer

This block is the digital controller of a single-cell switch-mode charger. It reads the analog comparators, a junction over-temperature flag, a VBUS power-on-reset pulse and the host control bits. From them it decides which current source the power stage uses and when the PWM stage runs. When the battery sits at its regulation voltage with the taper current reached, the block starts a termination sequence in three parts. A deglitch window comes first. A timed battery-presence check with a discharge sink follows. A synchronisation delay comes last, and only after it is the done status posted.

Every timer counts a 1 µs tick input. Their lengths are set in milliseconds through parameters, scaled by a ticks-per-millisecond parameter. While the die is too hot the block suspends charging and every phase timer keeps its count. When the resume flag asserts, the sequence continues from the same state. An open-drain status pin is modelled as a pull-low enable. It shows charging activity when the host allows it, and it gives a single fixed-length low pulse when thermal shutdown begins.

Top module: `charge_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle: `en_short`, `en_fast`, `en_pwm`, `en_sink`, `done` and `stat_pull_low` are all 0.
- R2: While charging, `en_pwm` is 1, `en_short` equals `bat_short` and `en_fast` equals its inverse. The two are never 1 together.
- R3: With `host_term_en` at 0 the block never terminates: `en_sink` and `done` stay 0 whatever the comparators show.
- R4: Termination begins only after `bat_reg`, `bat_above_rch` and `taper_hit` are all 1, with `host_term_en` at 1, for a continuous window of DGL_MS milliseconds of ticks. A drop of any of them restarts the window from zero.
- R5: During the presence check `en_pwm` is 0 and `en_sink` is 1 for DET_MS milliseconds of ticks. At the end the block samples `bat_above_rch`. If it is 1 the block goes on to the sync delay. If it is 0 the block returns to charging.
- R6: The sync delay lasts SYNC_MS milliseconds of ticks with the PWM stage and the sink both off. After it, `done` becomes 1.
- R7: With `host_ce` at 1, any of the following starts a new charge cycle, from any state: `bat_above_rch` falling to 0 while done; `vbus_por` while `bat_lowv` is 1; a rising edge of `host_ce`; a `host_reset` pulse. `vbus_por` with `bat_lowv` at 0 has no effect.
- R8: While `ot_flag` is 1 the block is suspended: `en_pwm`, `en_short`, `en_fast` and `en_sink` are all 0 from the next cycle, and the phase timers hold their counts. Suspension ends when `ot_resume` is 1 and `ot_flag` is 0. The same state then continues with its remaining time.
- R9: `stat_pull_low` is 1 while charging and not suspended, but only if `host_stat_en` is 1. Otherwise it is 0 (pin released), apart from the fault pulse.
- R10: Entry into thermal shutdown drives `stat_pull_low` to 1 for PULSE_TICKS ticks. A new entry while the pulse runs does not restart or lengthen it.
- R11: With `host_ce` at 0 the block stays in idle, with every enable and `done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle 1 µs time base strobe |
| bat_short | input | 1 | Battery below short-circuit threshold |
| bat_reg | input | 1 | Battery at regulation voltage |
| bat_above_rch | input | 1 | Battery above recharge threshold |
| taper_hit | input | 1 | Charge current down to termination level |
| ot_flag | input | 1 | Junction over-temperature (shutdown) |
| ot_resume | input | 1 | Junction cooled below shutdown minus hysteresis |
| vbus_por | input | 1 | VBUS power-on-reset pulse |
| bat_lowv | input | 1 | Battery below low-voltage threshold |
| host_ce | input | 1 | Host charge enable |
| host_reset | input | 1 | Host reset strobe (restart cycle) |
| host_term_en | input | 1 | Host termination enable |
| host_stat_en | input | 1 | Host status-pin enable |
| en_short | output | 1 | Short-circuit current enable |
| en_fast | output | 1 | Fast-charge current enable |
| en_pwm | output | 1 | PWM stage enable |
| en_sink | output | 1 | Detection discharge sink enable |
| done | output | 1 | Charge complete status |
| stat_pull_low | output | 1 | Open-drain status pin pull-down (1 = low) |

## Verification
A wrong sequencer state shows at the enables within one clock. A PWM enable that stays high during the presence check, or a sink enable that comes too early, is visible as soon as the deglitch window should still be running. A phase timer that runs during suspension, or one that fails to restart on a glitch, moves the next enable edge by whole windows. The bench therefore samples both sides of each expected edge, several ticks away from it. A fault pulse that gets retriggered outlasts its one expected length at the status pin by the spacing between the two faults.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHARGE = 3'd1,
    ST_DETECT = 3'd2,
    ST_SYNC   = 3'd3,
    ST_DONE   = 3'd4
  } cseq_state_e;

  function automatic int unsigned ms_ticks(input int unsigned ms, input int unsigned per_ms);
    return ms * per_ms;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cseq_timer.sv
module cseq_timer #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         hit
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && tick && (cnt < limit)) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt >= limit);

endmodule

// File: rtl/cseq_pulse.sv
module cseq_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic trig,
  output logic active
);
  localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(LEN - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (trig && !active) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && tick) begin
      if (cnt == LAST) active <= 1'b0;
      else             cnt    <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
  import cseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        force_idle,
  input  logic        restart,
  input  logic        hold,
  input  logic        term_q,
  input  logic        hit,
  input  logic        above_rch,
  output cseq_state_e st,
  output cseq_state_e nxt
);

  always_comb begin
    nxt = st;
    if (force_idle) nxt = ST_IDLE;
    else if (restart) nxt = ST_CHARGE;
    else if (!hold) begin
      case (st)
        ST_IDLE:   nxt = ST_CHARGE;
        ST_CHARGE: if (term_q && hit) nxt = ST_DETECT;
        ST_DETECT: if (hit) nxt = above_rch ? ST_SYNC : ST_CHARGE;
        ST_SYNC:   if (hit) nxt = ST_DONE;
        default:   nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

endmodule

// File: rtl/charge_seq.sv
module charge_seq
  import cseq_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned DGL_MS       = 32,
  parameter int unsigned DET_MS       = 262,
  parameter int unsigned SYNC_MS      = 40,
  parameter int unsigned PULSE_TICKS  = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic bat_short,
  input  logic bat_reg,
  input  logic bat_above_rch,
  input  logic taper_hit,
  input  logic ot_flag,
  input  logic ot_resume,
  input  logic vbus_por,
  input  logic bat_lowv,
  input  logic host_ce,
  input  logic host_reset,
  input  logic host_term_en,
  input  logic host_stat_en,
  output logic en_short,
  output logic en_fast,
  output logic en_pwm,
  output logic en_sink,
  output logic done,
  output logic stat_pull_low
);
  localparam int unsigned DGL_T  = ms_ticks(DGL_MS, TICKS_PER_MS);
  localparam int unsigned DET_T  = ms_ticks(DET_MS, TICKS_PER_MS);
  localparam int unsigned SYNC_T = ms_ticks(SYNC_MS, TICKS_PER_MS);
  localparam int          CW     = $clog2(max3(DGL_T, DET_T, SYNC_T) + 1);

  cseq_state_e st, nxt;
  logic        susp, ce_q;
  logic [CW-1:0] tcnt, tlimit;
  logic        thit, trun, tclr;
  logic        pulse_act;

  // named internal events
  logic term_q, ce_rise, ev_force_idle, ev_restart, ev_force;
  logic ev_sync_done, fault_evt, charging;

  always_ff @(posedge clk) begin
    if (rst) begin
      susp <= 1'b0;
      ce_q <= 1'b0;
    end else begin
      ce_q <= host_ce;
      if (ot_flag)        susp <= 1'b1;
      else if (ot_resume) susp <= 1'b0;
    end
  end

  assign term_q        = host_term_en && bat_reg && bat_above_rch && taper_hit;
  assign ce_rise       = host_ce && !ce_q;
  assign ev_force_idle = !host_ce;
  assign ev_restart    = host_ce && (ce_rise || host_reset || (vbus_por && bat_lowv) ||
                                     ((st == ST_DONE) && !bat_above_rch));
  assign ev_force      = ev_force_idle || ev_restart;
  assign fault_evt     = ot_flag && !susp;
  assign ev_sync_done  = (st == ST_SYNC) && (nxt == ST_DONE);
  assign charging      = (st == ST_CHARGE) && !susp;

  cseq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .force_idle (ev_force_idle),
    .restart    (ev_restart),
    .hold       (susp),
    .term_q     (term_q),
    .hit        (thit),
    .above_rch  (bat_above_rch),
    .st         (st),
    .nxt        (nxt)
  );

  always_comb begin
    case (st)
      ST_CHARGE: tlimit = CW'(DGL_T);
      ST_DETECT: tlimit = CW'(DET_T);
      ST_SYNC:   tlimit = CW'(SYNC_T);
      default:   tlimit = '0;
    endcase
  end

  assign trun = !susp && (((st == ST_CHARGE) && term_q) || (st == ST_DETECT) || (st == ST_SYNC));
  assign tclr = (nxt != st) || ((st == ST_CHARGE) && !term_q && !susp);

  cseq_timer #(.W(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_us),
    .run   (trun),
    .clr   (tclr),
    .limit (tlimit),
    .cnt   (tcnt),
    .hit   (thit)
  );

  cseq_pulse #(.LEN(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_us),
    .trig   (fault_evt),
    .active (pulse_act)
  );

  assign en_pwm        = charging;
  assign en_short      = charging && bat_short;
  assign en_fast       = charging && !bat_short;
  assign en_sink       = (st == ST_DETECT) && !susp;
  assign done          = (st == ST_DONE);
  assign stat_pull_low = pulse_act || (host_stat_en && charging);

endmodule

// File: rtl/cseq_chk.sv
module cseq_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         host_ce,
  input logic         ot_flag,
  input logic         host_term_en,
  input logic         host_stat_en,
  input logic         en_pwm,
  input logic         en_sink,
  input logic         en_short,
  input logic         en_fast,
  input logic         done,
  input logic         stat_pull_low,
  input logic         susp,
  input logic         ev_force,
  input logic         ev_sync_done,
  input logic         pulse_act,
  input logic [W-1:0] tcnt
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!en_pwm && !en_sink && !done && !stat_pull_low && !en_short && !en_fast));

  // R2
  one_source_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({en_short, en_fast}) <= 1);

  // R3
  no_term_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_term_en && !en_sink && !susp) |=> !en_sink);

  // R6
  done_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(ev_sync_done));

  // R8
  ot_off_chk: assert property (@(posedge clk) disable iff (rst)
    ot_flag |=> (!en_pwm && !en_sink && !en_short && !en_fast));

  // R8
  frozen_timer_chk: assert property (@(posedge clk) disable iff (rst)
    (susp && !ev_force) |=> $stable(tcnt));

  // R9
  stat_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_stat_en && !pulse_act) |-> !stat_pull_low);

  // R11
  ce_off_chk: assert property (@(posedge clk) disable iff (rst)
    !host_ce |=> (!en_pwm && !en_sink && !done));

endmodule

bind charge_seq cseq_chk #(.W(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .host_ce       (host_ce),
  .ot_flag       (ot_flag),
  .host_term_en  (host_term_en),
  .host_stat_en  (host_stat_en),
  .en_pwm        (en_pwm),
  .en_sink       (en_sink),
  .en_short      (en_short),
  .en_fast       (en_fast),
  .done          (done),
  .stat_pull_low (stat_pull_low),
  .susp          (susp),
  .ev_force      (ev_force),
  .ev_sync_done  (ev_sync_done),
  .pulse_act     (pulse_act),
  .tcnt          (tcnt)
);

// File: tb/charge_seq_bench.sv
module charge_seq_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0;
  logic bat_short = 0, bat_reg = 0, bat_above_rch = 0, taper_hit = 0;
  logic ot_flag = 0, ot_resume = 0, vbus_por = 0, bat_lowv = 0;
  logic host_ce = 0, host_reset = 0, host_term_en = 0, host_stat_en = 0;
  logic en_short, en_fast, en_pwm, en_sink, done, stat_pull_low;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // tick every other cycle, changed away from the active edge
  initial forever @(negedge clk) tick_us = ~tick_us;

  charge_seq #(
    .TICKS_PER_MS (1),
    .DGL_MS       (8),
    .DET_MS       (12),
    .SYNC_MS      (6),
    .PULSE_TICKS  (10)
  ) u_charge_seq (
    .clk (clk), .rst (rst), .tick_us (tick_us),
    .bat_short (bat_short), .bat_reg (bat_reg), .bat_above_rch (bat_above_rch),
    .taper_hit (taper_hit), .ot_flag (ot_flag), .ot_resume (ot_resume),
    .vbus_por (vbus_por), .bat_lowv (bat_lowv), .host_ce (host_ce),
    .host_reset (host_reset), .host_term_en (host_term_en), .host_stat_en (host_stat_en),
    .en_short (en_short), .en_fast (en_fast), .en_pwm (en_pwm), .en_sink (en_sink),
    .done (done), .stat_pull_low (stat_pull_low)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // enter the presence check from charging; 22 cycles after the conditions rise
  task automatic go_detect();
    host_term_en = 1; bat_reg = 1; bat_above_rch = 1; taper_hit = 1;
    cyc(22);
    taper_hit = 0;
    check("R4 sink after window", en_sink, 1'b1);
  endtask

  initial begin
    cyc(4);
    rst = 0;
    cyc(2);
    check("R1 en_pwm", en_pwm, 1'b0);
    check("R1 en_sink", en_sink, 1'b0);
    check("R1 done", done, 1'b0);
    check("R1 stat", stat_pull_low, 1'b0);
    check("R1 en_short", en_short, 1'b0);
    cyc(10);
    check("R11 idle while ce low", en_pwm, 1'b0);

    host_ce = 1; bat_short = 1;
    cyc(2);
    check("R2 short enabled", en_short, 1'b1);
    check("R2 fast off", en_fast, 1'b0);
    check("R2 pwm on", en_pwm, 1'b1);
    check("R9 stat released when disabled", stat_pull_low, 1'b0);
    host_stat_en = 1;
    cyc(1);
    check("R9 stat low while charging", stat_pull_low, 1'b1);
    bat_short = 0;
    cyc(1);
    check("R2 fast enabled", en_fast, 1'b1);
    check("R2 short off", en_short, 1'b0);

    // no termination with the bit cleared
    bat_reg = 1; bat_above_rch = 1; taper_hit = 1;
    cyc(60);
    check("R3 no sink", en_sink, 1'b0);
    check("R3 no done", done, 1'b0);
    check("R3 still charging", en_pwm, 1'b1);

    // deglitch with a glitch, then full termination
    host_term_en = 1;
    cyc(12);
    check("R4 sink not before window", en_sink, 1'b0);
    taper_hit = 0;
    cyc(2);
    taper_hit = 1;
    cyc(12);
    check("R4 window restarted after drop", en_sink, 1'b0);
    cyc(10);
    check("R5 sink on", en_sink, 1'b1);
    check("R5 pwm off", en_pwm, 1'b0);
    check("R9 stat released in check", stat_pull_low, 1'b0);
    cyc(16);
    check("R5 sink still on", en_sink, 1'b1);
    cyc(8);
    check("R5 sink off after check", en_sink, 1'b0);
    check("R6 pwm off in sync", en_pwm, 1'b0);
    cyc(4);
    check("R6 done not early", done, 1'b0);
    cyc(10);
    check("R6 done set", done, 1'b1);
    check("R9 stat released when done", stat_pull_low, 1'b0);
    taper_hit = 0;
    cyc(10);
    check("R6 done holds", done, 1'b1);

    // recharge restart
    bat_above_rch = 0;
    cyc(2);
    check("R7 recharge clears done", done, 1'b0);
    check("R7 recharge restarts pwm", en_pwm, 1'b1);

    // battery gone during check
    go_detect();
    bat_above_rch = 0;
    cyc(24);
    check("R5 back to charging", en_pwm, 1'b1);
    check("R5 no sync", en_sink, 1'b0);
    check("R5 no done", done, 1'b0);

    // VBUS POR
    go_detect();
    vbus_por = 1; bat_lowv = 0;
    cyc(1);
    vbus_por = 0;
    cyc(1);
    check("R7 por without lowv ignored", en_sink, 1'b1);
    vbus_por = 1; bat_lowv = 1;
    cyc(1);
    vbus_por = 0; bat_lowv = 0;
    cyc(1);
    check("R7 por with lowv restarts", en_pwm, 1'b1);
    check("R7 por sink off", en_sink, 1'b0);

    // host reset bit
    cyc(4);
    go_detect();
    host_reset = 1;
    cyc(1);
    host_reset = 0;
    check("R7 reset bit restarts", en_pwm, 1'b1);

    // charge-enable toggle
    cyc(4);
    go_detect();
    host_ce = 0;
    cyc(1);
    check("R11 ce low idles", en_pwm, 1'b0);
    check("R11 ce low sink off", en_sink, 1'b0);
    host_ce = 1;
    cyc(2);
    check("R7 ce rise restarts", en_pwm, 1'b1);

    // thermal suspension during the presence check
    host_stat_en = 0;
    cyc(4);
    go_detect();
    cyc(3);
    ot_flag = 1;
    cyc(2);
    check("R8 sink off while hot", en_sink, 1'b0);
    check("R8 pwm off while hot", en_pwm, 1'b0);
    cyc(4);
    check("R10 fault pulse low", stat_pull_low, 1'b1);
    cyc(20);
    check("R10 fault pulse ended", stat_pull_low, 1'b0);
    check("R8 still suspended", en_sink, 1'b0);
    ot_flag = 0; ot_resume = 1;
    cyc(1);
    ot_resume = 0;
    cyc(10);
    check("R8 check resumed with held time", en_sink, 1'b1);
    cyc(14);
    check("R8 check finished after remaining time", en_sink, 1'b0);

    // pulse not retriggered, in idle
    host_ce = 0;
    cyc(30);
    ot_flag = 1;
    cyc(1);
    ot_flag = 0; ot_resume = 1;
    cyc(1);
    ot_resume = 0;
    cyc(8);
    ot_flag = 1;
    cyc(1);
    ot_flag = 0; ot_resume = 1;
    cyc(1);
    ot_resume = 0;
    cyc(4);
    check("R10 pulse active", stat_pull_low, 1'b1);
    cyc(9);
    check("R10 pulse not lengthened", stat_pull_low, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule